// File: doc/BRIEF.md
# Calibration Trigger and Power-Up Sequencer

This controller decides when a converter calibration cycle begins and reports whether one is in progress. After reset is released (power-up), it counts a start-up settling delay. A select input picks one of two delay lengths. When the delay expires, it launches an automatic calibration. While the power-down input is high, the delay count is frozen.

Software or a board controller can also request a calibration through a single command pin. The request counts only when the pin has been held low for a minimum run of clocks and then high for a minimum run of clocks. A run that falls short of its minimum restarts detection. If the command pin is already high on the first clock after reset, the automatic calibration is cancelled and only a later qualified command can start one.

A calibration shows up as a one-clock start pulse, followed by a busy flag that lasts a fixed number of clocks. Power-down blocks every start. It also aborts a running calibration. The trimming work itself is done elsewhere; this block only sequences it.

Top module: `cal_sequencer`

## Requirements
- R1: With `dly_sel` = 0, `pwr_down` low and `cal_pin` low on the first clock after reset release, `cal_start` pulses on clock edge DLY_SHORT+1 after release.
- R2: With `dly_sel` = 1 and otherwise the same conditions as R1, `cal_start` pulses on clock edge DLY_LONG+1 after release.
- R3: The start-up delay counter only advances on edges where `pwr_down` is low, so a power-down period at power-up pushes the automatic start later by its own length.
- R4: If `cal_pin` is 1 on the first clock edge after reset release, no automatic calibration starts.
- R5: At least LOW_MIN consecutive low samples of `cal_pin`, followed by HIGH_MIN consecutive high samples, make `cal_start` pulse on the edge after the HIGH_MIN-th high sample.
- R6: A low run shorter than LOW_MIN, followed by any high run, starts nothing.
- R7: A qualified low run followed by a high run shorter than HIGH_MIN starts nothing. A later low sample restarts detection from zero.
- R8: `cal_start` is one clock wide. `cal_busy` rises on the next edge and stays high for exactly CAL_LEN clocks.
- R9: A command or an expired delay that completes while `cal_start` or `cal_busy` is high is discarded and starts nothing later.
- R10: No `cal_start` is issued on an edge where `pwr_down` is sampled high. A request that completes then is discarded.
- R11: `pwr_down` sampled high while busy clears `cal_busy` on that edge. Nothing restarts afterwards without a new command.
- R12: While reset is asserted, `cal_start` and `cal_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release marks power-up |
| cal_pin | input | 1 | Calibration command pin |
| dly_sel | input | 1 | Start-up delay choice: 0 short, 1 long |
| pwr_down | input | 1 | Power-down: freezes the delay, blocks and aborts calibration |
| cal_start | output | 1 | One-clock pulse when a calibration launches |
| cal_busy | output | 1 | High while calibration runs |

## Verification
Both outputs are registered. A request therefore appears as `cal_start` one edge after the request condition forms, and `cal_busy` follows one edge after that. An abort by power-down lands on the very edge that samples it. The bench drives inputs and compares outputs on falling edges. Its reference model advances on each rising edge from the same sampled inputs, so every due edge is compared exactly, including the edge where the automatic and command paths coincide. Per-scenario pulse counts then confirm the cases where nothing may start.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
   // Counter width able to hold the value n
   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   typedef enum logic [0:0] {
      RUN_IDLE = 1'b0,
      RUN_BUSY = 1'b1
   } run_state_t;
endpackage

// File: rtl/cal_cmd_detect.sv
module cal_cmd_detect #(
   parameter int LOW_MIN  = 3,
   parameter int HIGH_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_in,
   output logic cmd_hit
);
   import cal_seq_pkg::*;

   localparam int LW = cnt_w(LOW_MIN);
   localparam int HW = cnt_w(HIGH_MIN);
   localparam logic [LW-1:0] LOW_END  = LW'(LOW_MIN);
   localparam logic [HW-1:0] HIGH_END = HW'(HIGH_MIN);

   generate
      if (LOW_MIN < 1) begin : g_bad_low
         $error("LOW_MIN must be at least 1");
      end
      if (HIGH_MIN < 1) begin : g_bad_high
         $error("HIGH_MIN must be at least 1");
      end
   endgenerate

   logic [LW-1:0] low_run;
   logic [HW-1:0] high_run;
   logic          qual;

   assign cmd_hit = qual && (high_run == HIGH_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= '0;
         qual     <= 1'b0;
      end else if (cal_in) begin
         low_run <= '0;
         if (low_run == LOW_END) begin
            qual     <= 1'b1;
            high_run <= HW'(1);
         end else if (qual) begin
            if (cmd_hit) begin
               qual     <= 1'b0;
               high_run <= '0;
            end else begin
               high_run <= high_run + HW'(1);
            end
         end
      end else begin
         if (low_run != LOW_END) low_run <= low_run + LW'(1);
         qual     <= 1'b0;
         high_run <= '0;
      end
   end
endmodule

// File: rtl/cal_powerup_delay.sv
module cal_powerup_delay #(
   parameter int DLY_SHORT = 5,
   parameter int DLY_LONG  = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_in,
   input  logic dly_sel,
   input  logic pwr_down,
   output logic auto_hit
);
   import cal_seq_pkg::*;

   localparam int DMAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
   localparam int DW   = cnt_w(DMAX);

   generate
      if (DLY_SHORT < 1 || DLY_LONG < 1) begin : g_bad_dly
         $error("start-up delays must be at least 1");
      end
   endgenerate

   logic [DW-1:0] dly_cnt;
   logic [DW-1:0] target;
   logic          pending;
   logic          fresh;

   generate
      if (DLY_SHORT == DLY_LONG) begin : g_one_len
         assign target = DW'(DLY_SHORT);
         logic unused_sel;
         assign unused_sel = dly_sel;
      end else begin : g_two_len
         assign target = dly_sel ? DW'(DLY_LONG) : DW'(DLY_SHORT);
      end
   endgenerate

   assign auto_hit = pending && !pwr_down && (dly_cnt >= target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_cnt <= '0;
         pending <= 1'b1;
         fresh   <= 1'b1;
      end else begin
         fresh <= 1'b0;
         if ((fresh && cal_in) || auto_hit) begin
            pending <= 1'b0;
         end else if (pending && !pwr_down) begin
            dly_cnt <= dly_cnt + DW'(1);
         end
      end
   end
endmodule

// File: rtl/cal_run_timer.sv
module cal_run_timer #(
   parameter int CAL_LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic pwr_down,
   output logic cal_start,
   output logic cal_busy
);
   import cal_seq_pkg::*;

   localparam int CW = cnt_w(CAL_LEN);
   localparam logic [CW-1:0] LAST = CW'(CAL_LEN - 1);

   generate
      if (CAL_LEN < 1) begin : g_bad_len
         $error("CAL_LEN must be at least 1");
      end
   endgenerate

   run_state_t    state;
   logic [CW-1:0] run_cnt;

   assign cal_busy = (state == RUN_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_start <= 1'b0;
         state     <= RUN_IDLE;
         run_cnt   <= '0;
      end else begin
         cal_start <= req && !cal_busy && !pwr_down && !cal_start;
         if (cal_start && !pwr_down) begin
            state   <= RUN_BUSY;
            run_cnt <= '0;
         end else if (cal_busy) begin
            if (pwr_down || run_cnt == LAST) begin
               state <= RUN_IDLE;
            end else begin
               run_cnt <= run_cnt + CW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
   parameter int LOW_MIN   = 3,
   parameter int HIGH_MIN  = 2,
   parameter int CAL_LEN   = 6,
   parameter int DLY_SHORT = 5,
   parameter int DLY_LONG  = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_pin,
   input  logic dly_sel,
   input  logic pwr_down,
   output logic cal_start,
   output logic cal_busy
);
   logic cmd_hit;
   logic auto_hit;
   logic req;

   cal_cmd_detect #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cal_in  (cal_pin),
      .cmd_hit (cmd_hit)
   );

   cal_powerup_delay #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .cal_in   (cal_pin),
      .dly_sel  (dly_sel),
      .pwr_down (pwr_down),
      .auto_hit (auto_hit)
   );

   assign req = cmd_hit | auto_hit;

   cal_run_timer #(.CAL_LEN(CAL_LEN)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .pwr_down  (pwr_down),
      .cal_start (cal_start),
      .cal_busy  (cal_busy)
   );
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
   parameter int CAL_LEN = 6
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_down,
   input logic cal_start,
   input logic cal_busy
);
   logic [31:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_len <= '0;
      else if (cal_busy) run_len <= run_len + 32'd1;
      else               run_len <= '0;
   end

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);
   assert_busy_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_busy) |-> $past(cal_start));
   assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cal_busy) && !$past(pwr_down)) |-> (run_len == 32'(CAL_LEN)));
   assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> (run_len < 32'(CAL_LEN)));
   assert_no_start_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |-> !cal_busy);
   assert_no_start_in_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |-> !$past(pwr_down));
   assert_abort_on_pd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> !$past(pwr_down));
endmodule

bind cal_sequencer cal_sequencer_chk #(.CAL_LEN(CAL_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_down  (pwr_down),
   .cal_start (cal_start),
   .cal_busy  (cal_busy)
);

// File: tb/cal_sequencer_test.sv
`timescale 1ns/1ps
module cal_sequencer_test;
   localparam int LM = 3;
   localparam int HM = 2;
   localparam int CL = 6;
   localparam int DS = 5;
   localparam int DL = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cal_pin = 1'b0;
   logic dly_sel = 1'b0;
   logic pwr_down = 1'b0;
   logic cal_start;
   logic cal_busy;

   int n_tests = 0;
   int n_fail  = 0;
   int starts  = 0;
   bit done    = 0;
   string tag  = "R12";

   always #4 clk = ~clk;

   cal_sequencer #(.LOW_MIN(LM), .HIGH_MIN(HM), .CAL_LEN(CL),
                   .DLY_SHORT(DS), .DLY_LONG(DL)) uut (
      .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .dly_sel(dly_sel),
      .pwr_down(pwr_down), .cal_start(cal_start), .cal_busy(cal_busy));

   // behavioural reference
   int m_low, m_high, m_dcnt, m_left;
   bit m_qual, m_pend, m_fresh, m_start, m_busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_low = 0; m_high = 0; m_qual = 0; m_dcnt = 0; m_left = 0;
         m_pend = 1; m_fresh = 1; m_start = 0; m_busy = 0;
      end else begin
         bit hit, ahit, nstart;
         int tgt;
         tgt    = dly_sel ? DL : DS;
         hit    = m_qual && (m_high >= HM);
         ahit   = m_pend && !pwr_down && (m_dcnt >= tgt);
         nstart = (hit || ahit) && !m_busy && !pwr_down && !m_start;
         if (m_start && !pwr_down) begin
            m_busy = 1; m_left = CL;
         end else if (m_busy) begin
            if (pwr_down) m_busy = 0;
            else begin
               m_left--;
               if (m_left == 0) m_busy = 0;
            end
         end
         m_start = nstart;
         if ((m_fresh && cal_pin) || ahit) m_pend = 0;
         else if (m_pend && !pwr_down) m_dcnt++;
         m_fresh = 0;
         if (cal_pin) begin
            if (m_low >= LM) begin m_qual = 1; m_high = 1; end
            else if (m_qual) begin
               if (hit) begin m_qual = 0; m_high = 0; end
               else m_high++;
            end
            m_low = 0;
         end else begin
            m_low++; m_qual = 0; m_high = 0;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, cal_start, m_start, "cal_start vs model");
         check(tag, cal_busy, m_busy, "cal_busy vs model");
         if (cal_start) starts++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input bit cal0, input bit sel0, input bit pd0);
      rst_n = 1'b0; cal_pin = cal0; dly_sel = sel0; pwr_down = pd0;
      tick(3);
      check("R12", cal_start, 0, "cal_start in reset");
      check("R12", cal_busy, 0, "cal_busy in reset");
      rst_n = 1'b1;
      starts = 0;
   endtask

   task automatic pulse_cmd(input int lo, input int hi);
      cal_pin = 1'b0; tick(lo);
      cal_pin = 1'b1; tick(hi);
   endtask

   initial begin
      tick(1);
      // R1: short delay
      tag = "R1"; do_reset(0, 0, 0);
      tick(DS); check("R1", starts, 0, "no start before delay");
      tick(1);  check("R1", cal_start, 1, "start at DS+1");
      tick(25); check("R1", starts, 1, "single auto start");
      // R2: long delay
      tag = "R2"; do_reset(0, 1, 0);
      tick(DL); check("R2", starts, 0, "no start before long delay");
      tick(1);  check("R2", cal_start, 1, "start at DL+1");
      tick(25); check("R2", starts, 1, "single auto start");
      // R3: power-down freezes delay
      tag = "R3"; do_reset(0, 0, 1);
      tick(10); check("R3", starts, 0, "frozen while powered down");
      pwr_down = 0;
      tick(DS); check("R3", starts, 0, "delay restarts after power-down");
      tick(1);  check("R3", cal_start, 1, "start after delay resumes");
      tick(20); check("R3", starts, 1, "one start");
      // R4: cal high at power-up; R5: valid command
      tag = "R4"; do_reset(1, 0, 0);
      tick(30); check("R4", starts, 0, "auto cancelled");
      tag = "R5"; pulse_cmd(LM, HM);
      tick(1); check("R5", cal_start, 1, "command start");
      tick(12); check("R5", starts, 1, "command start count");
      // R6: short low
      tag = "R6"; pulse_cmd(LM - 1, 5);
      tick(3); check("R6", starts, 1, "short low ignored");
      // R7: short high then restart
      tag = "R7"; pulse_cmd(LM + 1, HM - 1);
      pulse_cmd(1, 4);
      tick(3); check("R7", starts, 1, "short high ignored");
      // R9: command during start and busy
      tag = "R9"; do_reset(0, 0, 0);
      tick(DS + 1); check("R9", cal_start, 1, "auto start");
      pulse_cmd(LM, HM);
      tick(15); check("R9", starts, 1, "command in busy dropped");
      // R10: power-down blocks command and auto
      tag = "R10"; do_reset(0, 0, 1);
      pulse_cmd(LM, HM);
      tick(8); check("R10", starts, 0, "blocked in power-down");
      pwr_down = 0;
      tick(DS + 1); check("R10", cal_start, 1, "auto after power-down");
      tick(10);
      // R11: abort on power-down
      tag = "R11"; do_reset(0, 0, 0);
      tick(DS + 2); check("R11", cal_busy, 1, "busy running");
      tick(1); pwr_down = 1; tick(1);
      check("R11", cal_busy, 0, "busy aborted");
      pwr_down = 0;
      tick(20); check("R11", starts, 1, "no restart after abort");
      check("R11", cal_busy, 0, "stays idle");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule